// File: doc/BRIEF.md
# CD Data Controller Register Port

This block is the byte-wide register window through which a host CPU programs and polls a CD data controller. A 4-bit index register picks one of sixteen slots. Reading a slot and writing a slot reach different registers. After most accesses the index steps forward by one, so a driver can stream a run of registers without reloading the index. The block holds the transfer byte count, transfer address, header bytes, pointer, write address, three control bytes and four status bytes.

The block starts a transfer when the trigger slot is written, clears a transfer end flag when the acknowledge slot is written, and applies a soft reset. The decoder status handshake arms the last status byte only after the CPU has read a fixed set of slots. The transfer engine sees the busy flag, the end flag and the live counters. It reports completion back through one strobe. The decoder raises its interrupt through another strobe. The header comes in as a 32-bit word, which is captured on a load strobe.

Top module: `cdc_reg_port`

## Requirements
- R1: After reset, reads of slots 0..F return 00, FF, 00, 00, 00, 00, 00, 01, 00, 00, 60, 12, 80, 00, 00, 00 in that order, busy_o and eot_o are 0, and all counter and control outputs are 0.
- R2: A read or write steps idx_o by one. A load on idx_ld_i sets idx_o to idx_i and takes priority over an access in the same cycle.
- R3: Reads of slot F and writes to slots 6, 7, E and F leave idx_o unchanged.
- R4: Read map: 0 returns 00, 1 returns the interface status byte, 2/3 return the byte count low/high, 4..7 return header bytes 0..3 (header byte k is head_i bits 8k+7..8k), 8/9 return the pointer low/high, A/B return the write address low/high, and C..F return status bytes 0..3.
- R5: Write map: 0 sets sbout_o, 1 sets ifctrl_o, 2/3 set the byte count low/high, 4/5 set dac_o low/high, 8/9 set the write address low/high, A/B set control bytes 0/1 (ctrl_o bits 7..0 and 15..8), C/D set the pointer low/high, and E sets control byte 2 (ctrl_o bits 23..16).
- R6: A write to slot 1 with data bit 1 clear sets the byte count to 0, clears busy_o and sets status bit 3.
- R7: A write to slot 6 while ifctrl_o bit 1 is set clears status bit 3, sets busy_o and clears eot_o. When ifctrl_o bit 1 is clear, the write has no effect.
- R8: xfer_done_i clears busy_o, sets eot_o and sets status bit 3. It also clears status bit 6 when ifctrl_o bit 6 is set. A write to slot 7 sets status bit 6.
- R9: dec_irq_i clears status bit 5. A read of slot F returns the current value of status byte 3 and sets status bit 5.
- R10: Reads of slots 1, 4..9 and C..E are recorded. A read of slot F changes status byte 3 to 80 only when ctrl_o bit 7 is set, ifctrl_o bit 5 is set, and all ten of those slots have been read since the last reset.
- R11: A write to slot F restores every register value of R1, clears busy_o, eot_o and the read record, and leaves idx_o at F.
- R12: head_ld_i captures head_i into the header bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_ld_i | input | 1 | Load strobe for the index |
| idx_i | input | 4 | Index value to load |
| idx_o | output | 4 | Current index |
| rd_i | input | 1 | CPU read strobe, one cycle per byte |
| wr_i | input | 1 | CPU write strobe, one cycle per byte |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | Read data of the slot selected by idx_o |
| head_ld_i | input | 1 | Header capture strobe |
| head_i | input | 32 | Header word from the disc position logic |
| dec_irq_i | input | 1 | Decoder interrupt event |
| xfer_done_i | input | 1 | Transfer engine completion event |
| busy_o | output | 1 | Transfer in progress |
| eot_o | output | 1 | End-of-transfer flag |
| dbc_o | output | 16 | Transfer byte count |
| dac_o | output | 16 | Transfer address |
| wa_o | output | 16 | Write address |
| pt_o | output | 16 | Pointer |
| ifctrl_o | output | 8 | Interface control byte |
| ctrl_o | output | 24 | Control bytes 2..0 |
| sbout_o | output | 8 | Status output byte |

## Verification
The bench targets the places where the read and write maps differ. It checks that a slot's hold rule depends on the direction of the access: reading slot E steps the index, while writing slot E does not. A design that used one hold rule for both would leave a streamed register run out of step. The STAT3 handshake is tested with each of its three conditions missing in turn, including a read record that lacks only slot 9. An early arm would show up as 80 where the bench expects 00, and a late arm would show up as 00 where the bench expects 80. The trigger is also written while transfers are disabled, and the soft reset is applied after every register holds a non-reset value.

// File: rtl/cdc_reg_pkg.sv
package cdc_reg_pkg;
  localparam int IDX_W = 4;
  localparam int NSLOT = 1 << IDX_W;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t SL_IF   = 4'h1;
  localparam idx_t SL_TRIG = 4'h6;
  localparam idx_t SL_ACK  = 4'h7;
  localparam idx_t SL_CTL2 = 4'hE;
  localparam idx_t SL_LAST = 4'hF;

  // slots whose reads feed the decode handshake
  localparam logic [NSLOT-1:0] TRACK_SET = 16'h73F2;

  function automatic logic idx_holds(input logic is_wr, input idx_t ix);
    if (is_wr) return (ix == SL_TRIG) || (ix == SL_ACK) || (ix == SL_CTL2) || (ix == SL_LAST);
    return ix == SL_LAST;
  endfunction
endpackage

// File: rtl/cdc_idx_ctr.sv
module cdc_idx_ctr
  import cdc_reg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  idx_t ld_val_i,
  input  logic rd_i,
  input  logic wr_i,
  output idx_t idx_o
);
  logic hold;
  assign hold = rd_i ? idx_holds(1'b0, idx_o) : idx_holds(1'b1, idx_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idx_o <= '0;
    else if (ld_i)            idx_o <= ld_val_i;
    else if ((rd_i || wr_i) && !hold) idx_o <= idx_o + 1'b1;
  end

  AST_IDX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> idx_o == $past(ld_val_i)); // R2
  AST_IDX_RD_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !ld_i && idx_o == SL_LAST) |=> $stable(idx_o)); // R3
  AST_IDX_WR_E: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ld_i && idx_o == SL_CTL2) |=> idx_o == SL_CTL2); // R3
endmodule

// File: rtl/cdc_rd_track.sv
module cdc_rd_track
  import cdc_reg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rd_i,
  input  idx_t idx_i,
  output logic full_o
);
  logic [NSLOT-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seen_q <= '0;
    else if (clr_i) seen_q <= '0;
    else if (rd_i && TRACK_SET[idx_i]) seen_q[idx_i] <= 1'b1;
  end

  assign full_o = &(seen_q | ~TRACK_SET);

  AST_SEEN_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (seen_q & $past(seen_q)) == $past(seen_q)); // R10
  AST_SEEN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !full_o); // R11
endmodule

// File: rtl/cdc_reg_file.sv
module cdc_reg_file
  import cdc_reg_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [2*DW-1:0] WA_RST = 16'd4704,
  parameter logic [DW-1:0]   IFS_RST = 8'hFF,
  parameter logic [4*DW-1:0] HEAD_RST = 32'h0100_0000,
  parameter logic [4*DW-1:0] STAT_RST = 32'h0000_0080
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  idx_t            idx_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            head_ld_i,
  input  logic [4*DW-1:0] head_i,
  input  logic            dec_irq_i,
  input  logic            xfer_done_i,
  input  logic            seen_full_i,
  output logic            soft_rst_o,
  output logic            busy_o,
  output logic            eot_o,
  output logic [2*DW-1:0] dbc_o,
  output logic [2*DW-1:0] dac_o,
  output logic [2*DW-1:0] wa_o,
  output logic [2*DW-1:0] pt_o,
  output logic [DW-1:0]   ifctrl_o,
  output logic [3*DW-1:0] ctrl_o,
  output logic [DW-1:0]   sbout_o
);
  localparam int CW = 2 * DW;
  localparam int WW = 4 * DW;

  logic [DW-1:0] ifstat_q;
  logic [WW-1:0] head_q, stat_q;
  logic          arm;

  assign soft_rst_o = wr_i && idx_i == SL_LAST;
  assign arm = ctrl_o[DW-1] && ifctrl_o[5] && seen_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifstat_q <= IFS_RST;  head_q <= HEAD_RST;  stat_q <= STAT_RST;
      dbc_o <= '0;  dac_o <= '0;  wa_o <= WA_RST;  pt_o <= '0;
      ifctrl_o <= '0;  ctrl_o <= '0;  sbout_o <= '0;
      busy_o <= 1'b0;  eot_o <= 1'b0;
    end else begin
      if (head_ld_i) head_q <= head_i;
      if (dec_irq_i) ifstat_q[5] <= 1'b0;
      if (xfer_done_i) begin
        busy_o <= 1'b0;  eot_o <= 1'b1;  ifstat_q[3] <= 1'b1;
        if (ifctrl_o[6]) ifstat_q[6] <= 1'b0;
      end
      if (wr_i) begin
        unique case (idx_i)
          4'h0: sbout_o <= wdata_i;
          4'h1: begin
            ifctrl_o <= wdata_i;
            if (!wdata_i[1]) begin
              dbc_o <= '0;  busy_o <= 1'b0;  ifstat_q[3] <= 1'b1;
            end
          end
          4'h2: dbc_o[DW-1:0]  <= wdata_i;
          4'h3: dbc_o[CW-1:DW] <= wdata_i;
          4'h4: dac_o[DW-1:0]  <= wdata_i;
          4'h5: dac_o[CW-1:DW] <= wdata_i;
          4'h6: if (ifctrl_o[1]) begin
            ifstat_q[3] <= 1'b0;  busy_o <= 1'b1;  eot_o <= 1'b0;
          end
          4'h7: ifstat_q[6] <= 1'b1;
          4'h8: wa_o[DW-1:0]  <= wdata_i;
          4'h9: wa_o[CW-1:DW] <= wdata_i;
          4'hA: ctrl_o[DW-1:0]    <= wdata_i;
          4'hB: ctrl_o[2*DW-1:DW] <= wdata_i;
          4'hC: pt_o[DW-1:0]  <= wdata_i;
          4'hD: pt_o[CW-1:DW] <= wdata_i;
          4'hE: ctrl_o[3*DW-1:2*DW] <= wdata_i;
          default: begin
            ifstat_q <= IFS_RST;  head_q <= HEAD_RST;  stat_q <= STAT_RST;
            dbc_o <= '0;  dac_o <= '0;  wa_o <= WA_RST;  pt_o <= '0;
            ifctrl_o <= '0;  ctrl_o <= '0;  sbout_o <= '0;
            busy_o <= 1'b0;  eot_o <= 1'b0;
          end
        endcase
      end else if (rd_i && idx_i == SL_LAST) begin
        ifstat_q[5] <= 1'b1;
        if (arm) stat_q[WW-1:3*DW] <= 8'h80;
      end
    end
  end

  always_comb begin
    unique case (idx_i)
      4'h0: rdata_o = '0;
      4'h1: rdata_o = ifstat_q;
      4'h2: rdata_o = dbc_o[DW-1:0];
      4'h3: rdata_o = dbc_o[CW-1:DW];
      4'h8: rdata_o = pt_o[DW-1:0];
      4'h9: rdata_o = pt_o[CW-1:DW];
      4'hA: rdata_o = wa_o[DW-1:0];
      4'hB: rdata_o = wa_o[CW-1:DW];
      4'h4, 4'h5, 4'h6, 4'h7: rdata_o = head_q[idx_i[1:0]*DW +: DW];
      default: rdata_o = stat_q[idx_i[1:0]*DW +: DW];
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i)); // R2
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == SL_IF && !wdata_i[1]) |=> (!busy_o && dbc_o == '0 && ifstat_q[3])); // R6
  AST_TRIG_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == SL_TRIG && ifctrl_o[1]) |=> (busy_o && !eot_o && !ifstat_q[3])); // R7
  AST_TRIG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == SL_TRIG && !ifctrl_o[1] && !xfer_done_i) |=> $stable(busy_o)); // R7
  AST_ACK_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == SL_ACK) |=> ifstat_q[6]); // R8
  AST_STAT3_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && idx_i == SL_LAST) |=> ifstat_q[5]); // R9
  AST_STAT3_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && idx_i == SL_LAST && arm) |=> stat_q[WW-1:3*DW] == 8'h80); // R10
  AST_SOFT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (!busy_o && wa_o == WA_RST && ifstat_q == IFS_RST)); // R11
endmodule

// File: rtl/cdc_reg_port.sv
module cdc_reg_port
  import cdc_reg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        idx_ld_i,
  input  logic [3:0]  idx_i,
  output logic [3:0]  idx_o,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        head_ld_i,
  input  logic [31:0] head_i,
  input  logic        dec_irq_i,
  input  logic        xfer_done_i,
  output logic        busy_o,
  output logic        eot_o,
  output logic [15:0] dbc_o,
  output logic [15:0] dac_o,
  output logic [15:0] wa_o,
  output logic [15:0] pt_o,
  output logic [7:0]  ifctrl_o,
  output logic [23:0] ctrl_o,
  output logic [7:0]  sbout_o
);
  logic seen_full, soft_rst;

  cdc_idx_ctr u_idx (
    .clk_i, .rst_ni, .ld_i(idx_ld_i), .ld_val_i(idx_i),
    .rd_i, .wr_i, .idx_o
  );

  cdc_rd_track u_trk (
    .clk_i, .rst_ni, .clr_i(soft_rst), .rd_i(rd_i && !wr_i),
    .idx_i(idx_o), .full_o(seen_full)
  );

  cdc_reg_file #(.DW(8)) u_regs (
    .clk_i, .rst_ni, .idx_i(idx_o), .rd_i, .wr_i, .wdata_i, .rdata_o,
    .head_ld_i, .head_i, .dec_irq_i, .xfer_done_i,
    .seen_full_i(seen_full), .soft_rst_o(soft_rst),
    .busy_o, .eot_o, .dbc_o, .dac_o, .wa_o, .pt_o,
    .ifctrl_o, .ctrl_o, .sbout_o
  );
endmodule

// File: tb/sim_cdc_reg_port.sv
`timescale 1ns/1ps
module sim_cdc_reg_port;
  logic clk = 0, rst_n = 0;
  logic idx_ld = 0, rd = 0, wr = 0, head_ld = 0, dec_irq = 0, xdone = 0;
  logic [3:0] idx_v = 0, idx_q;
  logic [7:0] wd = 0, rdat, ifc, sbo;
  logic [31:0] head = 0;
  logic busy, eot;
  logic [15:0] dbc, dac, wa, pt;
  logic [23:0] ctl;
  int n_run = 0, n_bad = 0, cyc = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  cdc_reg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .idx_ld_i(idx_ld), .idx_i(idx_v), .idx_o(idx_q),
    .rd_i(rd), .wr_i(wr), .wdata_i(wd), .rdata_o(rdat),
    .head_ld_i(head_ld), .head_i(head), .dec_irq_i(dec_irq), .xfer_done_i(xdone),
    .busy_o(busy), .eot_o(eot), .dbc_o(dbc), .dac_o(dac), .wa_o(wa), .pt_o(pt),
    .ifctrl_o(ifc), .ctrl_o(ctl), .sbout_o(sbo)
  );

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", r, got, exp);
    end
  endtask

  task automatic set_idx(input logic [3:0] x);
    idx_ld = 1; idx_v = x; @(negedge clk); idx_ld = 0;
  endtask
  task automatic wr_b(input logic [7:0] d);
    wr = 1; wd = d; @(negedge clk); wr = 0;
  endtask
  task automatic rd_b(output logic [7:0] o);
    o = rdat; rd = 1; @(negedge clk); rd = 0;
  endtask
  task automatic rd_at(input logic [3:0] x, output logic [7:0] o);
    set_idx(x); rd_b(o);
  endtask
  task automatic soft_reset();
    set_idx(4'hF); wr_b(8'h00);
  endtask
  // read the tracked slots, optionally leaving slot 9 out
  task automatic read_tracked(input bit skip9);
    logic [7:0] t;
    rd_at(4'h1, t);
    set_idx(4'h4);
    for (int k = 4; k <= 9; k++) begin
      if (k == 9 && skip9) break;
      rd_b(t);
    end
    set_idx(4'hC);
    for (int k = 0; k < 3; k++) rd_b(t);
  endtask

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      1: return 8'hFF;  7: return 8'h01;  10: return 8'h60;
      11: return 8'h12; 12: return 8'h80; default: return 8'h00;
    endcase
  endfunction
  function automatic logic [7:0] wv(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic reset_sweep(input string r);
    set_idx(4'h0);
    for (int i = 0; i < 16; i++) begin
      chk(r, idx_q, i);
      rd_b(v);
      chk(r, v, rst_val(i));
    end
    chk(r, idx_q, 4'hF);
    chk(r, {busy, eot}, 2'b00);
    chk(r, {dbc, dac, pt}, 48'h0);
    chk(r, {ctl, ifc, sbo}, 40'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog got=%0d exp=<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values, R4 read map, R3 hold on read of F
    reset_sweep("R1");

    // R5 write map with R2 auto-increment, R3 hold on write of E
    set_idx(4'h0);
    for (int i = 0; i < 6; i++) wr_b(wv(i));
    chk("R2", idx_q, 4'h6);
    set_idx(4'h8);
    for (int i = 8; i < 14; i++) wr_b(wv(i));
    chk("R2", idx_q, 4'hE);
    wr_b(wv(14));
    chk("R3", idx_q, 4'hE);
    rd_b(v);
    chk("R3", idx_q, 4'hF);
    chk("R5", sbo, wv(0));
    chk("R5", ifc, wv(1));
    chk("R5", dbc, {wv(3), wv(2)});
    chk("R5", dac, {wv(5), wv(4)});
    chk("R5", wa, {wv(9), wv(8)});
    chk("R5", pt, {wv(13), wv(12)});
    chk("R5", ctl, {wv(14), wv(11), wv(10)});
    set_idx(4'h2);
    rd_b(v); chk("R4", v, wv(2));
    rd_b(v); chk("R4", v, wv(3));
    set_idx(4'h8);
    rd_b(v); chk("R4", v, wv(12));
    rd_b(v); chk("R4", v, wv(13));
    rd_b(v); chk("R4", v, wv(8));
    rd_b(v); chk("R4", v, wv(9));

    // R2 load beats a simultaneous access
    idx_ld = 1; idx_v = 4'h3; rd = 1; @(negedge clk); idx_ld = 0; rd = 0;
    chk("R2", idx_q, 4'h3);

    // R12 header capture
    head = 32'hA1B2_C3D4; head_ld = 1; @(negedge clk); head_ld = 0;
    set_idx(4'h4);
    for (int k = 0; k < 4; k++) begin
      rd_b(v); chk("R12", v, head[8*k +: 8]);
    end

    // R11 soft reset after everything holds non-reset values
    soft_reset();
    chk("R11", idx_q, 4'hF);
    reset_sweep("R11");

    // R7 / R8 trigger, completion, acknowledge
    soft_reset();
    set_idx(4'h1); wr_b(8'h02); wr_b(8'h10); wr_b(8'h00);
    chk("R5", dbc, 16'h0010);
    xdone = 1; @(negedge clk); xdone = 0;
    chk("R8", {busy, eot}, 2'b01);
    set_idx(4'h6); wr_b(8'h00);
    chk("R7", {busy, eot}, 2'b10);
    chk("R3", idx_q, 4'h6);
    rd_at(4'h1, v); chk("R7", v, 8'hF7);
    set_idx(4'h1); wr_b(8'h42);
    xdone = 1; @(negedge clk); xdone = 0;
    chk("R8", {busy, eot}, 2'b01);
    rd_at(4'h1, v); chk("R8", v, 8'hBF);
    set_idx(4'h7); wr_b(8'h00);
    chk("R3", idx_q, 4'h7);
    rd_at(4'h1, v); chk("R8", v, 8'hFF);

    // R6 stop during a transfer
    set_idx(4'h2); wr_b(8'h34); wr_b(8'h12);
    set_idx(4'h6); wr_b(8'h00);
    chk("R7", busy, 1'b1);
    set_idx(4'h1); wr_b(8'h40);
    chk("R6", busy, 1'b0);
    chk("R6", dbc, 16'h0000);
    rd_at(4'h1, v); chk("R6", v, 8'hFF);
    // R7 trigger ignored while disabled
    set_idx(4'h6); wr_b(8'h00);
    chk("R7", busy, 1'b0);
    rd_at(4'h1, v); chk("R7", v, 8'hFF);

    // R9 decode flag handshake
    dec_irq = 1; @(negedge clk); dec_irq = 0;
    rd_at(4'h1, v); chk("R9", v, 8'hDF);
    rd_at(4'hF, v); chk("R9", v, 8'h00);
    chk("R3", idx_q, 4'hF);
    rd_at(4'h1, v); chk("R9", v, 8'hFF);

    // R10 arm: ctrl bit 7 missing
    soft_reset();
    set_idx(4'h1); wr_b(8'h20);
    read_tracked(0);
    rd_at(4'hF, v); rd_b(v); chk("R10", v, 8'h00);
    // R10 arm: ifctrl bit 5 missing
    soft_reset();
    set_idx(4'hA); wr_b(8'h80);
    read_tracked(0);
    rd_at(4'hF, v); rd_b(v); chk("R10", v, 8'h00);
    // R10 arm: slot 9 not yet read, then read
    soft_reset();
    set_idx(4'h1); wr_b(8'h20);
    set_idx(4'hA); wr_b(8'h80);
    read_tracked(1);
    rd_at(4'hF, v); rd_b(v); chk("R10", v, 8'h00);
    rd_at(4'h9, v);
    rd_at(4'hF, v); chk("R10", v, 8'h00);
    rd_b(v); chk("R10", v, 8'h80);
    // R11 soft reset drops the read record and the armed byte
    soft_reset();
    set_idx(4'h1); wr_b(8'h20);
    set_idx(4'hA); wr_b(8'h80);
    rd_at(4'hF, v); rd_b(v); chk("R11", v, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule